// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This peripheral watches over system software with a down-counter that runs on the system clock. The counter is reloaded through a small register bus. If software stops writing the reload value, the counter reaches zero. The block then raises a level interrupt, so that a handler can record what went wrong. If the counter reaches zero a second time while that interrupt is still pending and reset escalation is enabled, the block emits a one-cycle system reset pulse.

A key written to a dedicated register protects every register from accidental writes. Writing the key opens the registers, and writing any other value to the same register closes them again. The enable bit cannot be cleared once it is set. An optional debug mode stops the counter while an external halt input is high, so that a paused processor is not reset.

The bus has a 3-bit word address, 32-bit write data, a write strobe, combinational read data and a write acknowledge.

Top module: `wdog_timer`

## Requirements
- R1: After reset the block is unlocked (lock register at address 7 reads 0). The load register (address 0) and the current value (address 1) both read 0xFFFFFFFF. The counter does not move. Control (address 2), raw status (address 4) and masked status (address 5) read 0, and `irq_o` and `sys_rst_o` are low.
- R2: Writing 0x1ACCE551 to address 7 unlocks the registers. Writing any other value to address 7 locks them. Address 7 reads 1 while locked and 0 while unlocked.
- R3: While the block is locked, writes to the load (0), control (2), clear (3) and test (6) registers have no effect.
- R4: Control bit 0 starts counting and enables the interrupt, and once set it stays set until reset. Control bit 1 enables reset escalation and can be written either way.
- R5: A write to the load register copies the written value into the counter on the same clock edge. While enabled, the counter then drops by one on each clock.
- R6: In the clock after the counter has read 0, the counter takes the load value and raw status bit 0 is set. Counting carries on.
- R7: If the counter runs out while raw status is already set and control bit 1 is 1, `sys_rst_o` is high for exactly one cycle. On that edge raw status is cleared and the counter is reloaded. With control bit 1 at 0, no reset is issued and raw status stays set.
- R8: Any write to the clear register (address 3) clears raw status, unless a run-out sets it on the same edge.
- R9: Masked status bit 0 and `irq_o` equal raw status ANDed with control bit 0.
- R10: While test register bit 8 is 1 and `halt_i` is high, the counter holds its value. With bit 8 at 0, `halt_i` has no effect.
- R11: `ready_o` is high in the cycle after each write strobe and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i |
| ready_o | output | 1 | Write acknowledge |
| halt_i | input | 1 | Debug halt request |
| irq_o | output | 1 | Timeout interrupt (level) |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Load values from 0 to 5 are swept with escalation off. For each value the bench reads the counter every cycle. This separates an off-by-one in the count or reload from a wrong run-out cycle. It also shows that a second run-out with escalation off leaves status set and raises no reset. A short load is then run with escalation on, once with a clear between the two run-outs and once without. This pair tells a correct two-stage escalation apart from a reset on the first run-out or a reset that ignores the clear. Locked writes to each protected register, wrong and correct keys, and halt with the stall bit on and off complete the patterns.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned STALL_BIT = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOAD   = 3'd0,
        REG_VALUE  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_CLEAR  = 3'd3,
        REG_RAW    = 3'd4,
        REG_MASKED = 3'd5,
        REG_TEST   = 3'd6,
        REG_LOCK   = 3'd7
    } wdog_reg_e;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned DW  = 32,
    parameter logic [DW-1:0] KEY = 32'h1ACCE551
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic                wr_i,
    output logic                locked_o,
    output logic [DW-1:0]       load_o,
    output logic                en_o,
    output logic                rst_en_o,
    output logic                stall_o,
    output logic                load_wr_o,
    output logic                clr_wr_o
);
    typedef struct packed {
        logic          locked;
        logic [DW-1:0] load;
        logic          en;
        logic          rst_en;
        logic          stall;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  wr_ok;

    always_comb begin
        s_d       = s_q;
        wr_ok     = wr_i && !s_q.locked;
        load_wr_o = 1'b0;
        clr_wr_o  = 1'b0;
        if (wr_i && wdog_reg_e'(addr_i) == REG_LOCK) begin
            s_d.locked = (wdata_i != KEY);
        end
        if (wr_ok) begin
            case (wdog_reg_e'(addr_i))
                REG_LOAD: begin
                    s_d.load  = wdata_i;
                    load_wr_o = 1'b1;
                end
                REG_CTRL: begin
                    s_d.en     = s_q.en | wdata_i[0];
                    s_d.rst_en = wdata_i[1];
                end
                REG_CLEAR: clr_wr_o  = 1'b1;
                REG_TEST:  s_d.stall = wdata_i[STALL_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.locked <= 1'b0;
            s_q.load   <= '1;
            s_q.en     <= 1'b0;
            s_q.rst_en <= 1'b0;
            s_q.stall  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign locked_o = s_q.locked;
    assign load_o   = s_q.load;
    assign en_o     = s_q.en;
    assign rst_en_o = s_q.rst_en;
    assign stall_o  = s_q.stall;
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          rst_en_i,
    input  logic          stall_i,
    input  logic          halt_i,
    input  logic          load_wr_i,
    input  logic [DW-1:0] wr_val_i,
    input  logic [DW-1:0] reload_i,
    input  logic          clr_wr_i,
    output logic [DW-1:0] cnt_o,
    output logic          raw_o,
    output logic          rst_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          raw;
        logic          rst;
    } core_t;

    core_t s_d, s_q;
    logic  run;
    logic  pending;

    always_comb begin
        s_d     = s_q;
        s_d.rst = 1'b0;
        run     = en_i && !(stall_i && halt_i);
        pending = s_q.raw && !clr_wr_i;
        if (clr_wr_i) begin
            s_d.raw = 1'b0;
        end
        if (load_wr_i) begin
            s_d.cnt = wr_val_i;
        end else if (run) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = reload_i;
                if (pending && rst_en_i) begin
                    s_d.rst = 1'b1;
                    s_d.raw = 1'b0;
                end else begin
                    s_d.raw = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt <= '1;
            s_q.raw <= 1'b0;
            s_q.rst <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign raw_o = s_q.raw;
    assign rst_o = s_q.rst;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              wr_i,
    output logic [DW-1:0]     rdata_o,
    output logic              ready_o,
    input  logic              halt_i,
    output logic              irq_o,
    output logic              sys_rst_o
);
    logic          lock_st;
    logic [DW-1:0] load_q;
    logic          en_st;
    logic          rst_en_st;
    logic          stall_st;
    logic          load_wr;
    logic          clr_wr;
    logic [DW-1:0] cnt_val;
    logic          raw_st;
    logic          rdy_d, rdy_q;

    wdog_ctrl #(.DW(DW)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .wr_i      (wr_i),
        .locked_o  (lock_st),
        .load_o    (load_q),
        .en_o      (en_st),
        .rst_en_o  (rst_en_st),
        .stall_o   (stall_st),
        .load_wr_o (load_wr),
        .clr_wr_o  (clr_wr)
    );

    wdog_core #(.DW(DW)) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_st),
        .rst_en_i  (rst_en_st),
        .stall_i   (stall_st),
        .halt_i    (halt_i),
        .load_wr_i (load_wr),
        .wr_val_i  (wdata_i),
        .reload_i  (load_q),
        .clr_wr_i  (clr_wr),
        .cnt_o     (cnt_val),
        .raw_o     (raw_st),
        .rst_o     (sys_rst_o)
    );

    assign irq_o = raw_st & en_st;

    always_comb begin
        rdata_o = '0;
        case (wdog_reg_e'(addr_i))
            REG_LOAD:   rdata_o = load_q;
            REG_VALUE:  rdata_o = cnt_val;
            REG_CTRL:   rdata_o[1:0] = {rst_en_st, en_st};
            REG_RAW:    rdata_o[0] = raw_st;
            REG_MASKED: rdata_o[0] = irq_o;
            REG_TEST:   rdata_o[STALL_BIT] = stall_st;
            REG_LOCK:   rdata_o[0] = lock_st;
            default:    rdata_o = '0;
        endcase
    end

    always_comb rdy_d = wr_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdy_q <= 1'b0;
        else         rdy_q <= rdy_d;
    end

    assign ready_o = rdy_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic              ready_o,
    input logic              halt_i,
    input logic              sys_rst_o,
    input logic              lock_st,
    input logic [DW-1:0]     load_q,
    input logic              en_st,
    input logic              stall_st,
    input logic              raw_st,
    input logic [DW-1:0]     cnt_val
);
    logic load_hit;
    assign load_hit = wr_i && !lock_st && (addr_i == REG_LOAD);

    a_r3_locked_load_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && lock_st && addr_i == REG_LOAD) |=> $stable(load_q));

    a_r4_enable_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_st |=> en_st);

    a_r5_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_st && !load_hit) |=> $stable(cnt_val));

    a_r7_reset_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_o |=> !sys_rst_o);

    a_r7_reset_after_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_o |-> ($past(raw_st) && !raw_st));

    a_r10_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_st && stall_st && halt_i && !load_hit) |=> $stable(cnt_val));

    a_r11_ready_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ready_o);

    a_r11_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> !ready_o);
endmodule

bind wdog_timer wdog_timer_chk #(.DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .ready_o   (ready_o),
    .halt_i    (halt_i),
    .sys_rst_o (sys_rst_o),
    .lock_st   (lock_st),
    .load_q    (load_q),
    .en_st     (en_st),
    .stall_st  (stall_st),
    .raw_st    (raw_st),
    .cnt_val   (cnt_val)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        halt = 1'b0;
    logic [31:0] rdata;
    logic        ready, irq, sys_rst;

    int errors = 0;
    int checks = 0;
    int rst_seen = 0;

    always #4 clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_i(wr), .rdata_o(rdata), .ready_o(ready), .halt_i(halt),
        .irq_o(irq), .sys_rst_o(sys_rst)
    );

    always @(negedge clk) if (rst_n && sys_rst) rst_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd_reg(3'd7, v); chk("R1 lock", v, 0);
        rd_reg(3'd0, v); chk("R1 load", v, 32'hFFFFFFFF);
        rd_reg(3'd2, v); chk("R1 ctrl", v, 0);
        rd_reg(3'd4, v); chk("R1 raw", v, 0);
        rd_reg(3'd5, v); chk("R1 masked", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 sys_rst", {31'b0, sys_rst}, 0);
        tick(4);
        rd_reg(3'd1, v); chk("R1 stopped", v, 32'hFFFFFFFF);

        // R11 ready after write
        addr = 3'd6; wdata = 0; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        chk("R11 ready high", {31'b0, ready}, 1);
        tick(1);
        chk("R11 ready low", {31'b0, ready}, 0);

        // R5 load while stopped
        wr_reg(3'd0, 32'd40);
        rd_reg(3'd1, v); chk("R5 load stopped", v, 40);
        tick(2);
        rd_reg(3'd1, v); chk("R5 stopped hold", v, 40);

        // R4 enable (bit1 off), counting starts next edge
        wr_reg(3'd2, 32'd1);
        rd_reg(3'd1, v); chk("R4 enable edge", v, 40);
        tick(1);
        rd_reg(3'd1, v); chk("R4 counting", v, 39);
        wr_reg(3'd2, 32'd0);
        rd_reg(3'd2, v); chk("R4 sticky", v, 1);

        // R5/R6/R7/R9 sweep of load values
        for (int n = 0; n <= 5; n++) begin
            wr_reg(3'd0, 32'd100);
            wr_reg(3'd3, 32'd0);
            wr_reg(3'd0, n);
            for (int k = 0; k <= n; k++) begin
                rd_reg(3'd1, v); chk("R5 count", v, n - k);
                rd_reg(3'd4, v); chk("R6 raw before", v, 0);
                tick(1);
            end
            rd_reg(3'd1, v); chk("R6 reload", v, n);
            rd_reg(3'd4, v); chk("R6 raw set", v, 1);
            rd_reg(3'd5, v); chk("R9 masked", v, 1);
            chk("R9 irq", {31'b0, irq}, 1);
            tick(n + 1);
            rd_reg(3'd4, v); chk("R7 no escalate raw", v, 1);
            rd_reg(3'd1, v); chk("R7 no escalate reload", v, n);
        end
        chk("R7 no reset when disabled", rst_seen, 0);

        // R7 escalation with bit1 set
        wr_reg(3'd2, 32'd3);
        rd_reg(3'd2, v); chk("R4 bit1 set", v, 3);
        wr_reg(3'd0, 32'd100);
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd0, 32'd3);
        tick(4);
        rd_reg(3'd4, v); chk("R6 first runout", v, 1);
        chk("R7 no reset first", {31'b0, sys_rst}, 0);
        tick(4);
        chk("R7 reset pulse", {31'b0, sys_rst}, 1);
        rd_reg(3'd4, v); chk("R7 raw cleared", v, 0);
        rd_reg(3'd1, v); chk("R7 reload", v, 3);
        tick(1);
        chk("R7 pulse ends", {31'b0, sys_rst}, 0);
        rd_reg(3'd1, v); chk("R7 counting on", v, 2);
        chk("R7 one pulse", rst_seen, 1);

        // R8 clear between run-outs avoids reset
        wr_reg(3'd0, 32'd3);
        tick(4);
        rd_reg(3'd4, v); chk("R8 raw set", v, 1);
        wr_reg(3'd3, 32'hABCD);
        rd_reg(3'd4, v); chk("R8 cleared", v, 0);
        tick(4);
        chk("R8 no reset", rst_seen, 1);
        rd_reg(3'd4, v); chk("R8 raw again", v, 1);

        // R2/R3 lock behaviour
        wr_reg(3'd0, 32'd200);
        wr_reg(3'd7, KEY ^ 32'h1);
        rd_reg(3'd7, v); chk("R2 wrong key locks", v, 1);
        wr_reg(3'd0, 32'd7);
        rd_reg(3'd0, v); chk("R3 load ignored", v, 200);
        rd_reg(3'd1, v); chk("R3 counter not loaded", v, 198);
        wr_reg(3'd2, 32'd0);
        rd_reg(3'd2, v); chk("R3 ctrl ignored", v, 3);
        wr_reg(3'd3, 32'd0);
        rd_reg(3'd4, v); chk("R3 clear ignored", v, 1);
        wr_reg(3'd6, 32'h100);
        rd_reg(3'd6, v); chk("R3 test ignored", v, 0);
        wr_reg(3'd7, KEY);
        rd_reg(3'd7, v); chk("R2 key unlocks", v, 0);
        wr_reg(3'd3, 32'd0);
        rd_reg(3'd4, v); chk("R8 clear after unlock", v, 0);
        wr_reg(3'd7, 32'h0);
        rd_reg(3'd7, v); chk("R2 relock", v, 1);
        wr_reg(3'd7, KEY);

        // R10 debug stall
        wr_reg(3'd0, 32'd50);
        halt = 1'b1;
        tick(3);
        rd_reg(3'd1, v); chk("R10 halt ignored", v, 47);
        wr_reg(3'd6, 32'h100);
        rd_reg(3'd6, v); chk("R10 test bit", v, 32'h100);
        rd_reg(3'd1, v); chk("R10 hold at write", v, 46);
        tick(3);
        rd_reg(3'd1, v); chk("R10 hold", v, 46);
        halt = 1'b0;
        tick(2);
        rd_reg(3'd1, v); chk("R10 resume", v, 44);
        chk("R9 irq low", {31'b0, irq}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule